// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block collects 64 level-sensitive interrupt request lines, each with its own enable bit and 4-bit priority, and selects one winner among the requests that are high, enabled and above a programmable priority threshold. A single interrupt output goes high whenever a winner exists. Software reads a vector status word that carries the winning source number and its priority. It reads all ones when no source qualifies.

Software can change enables in two ways. It can write one source number to set or clear that source's enable bit, or it can write a 32-bit mask that sets or clears many enables in one half of the source range at once. Priorities are stored eight per word as nibbles, and the word index counts downward as the source group rises. An interrupt handler typically raises the threshold to the level it is serving, which blocks requests of equal and lower priority until it restores the old threshold.

Selection is purely combinational from the request lines and the stored state. The output and the status word therefore follow the inputs within the same cycle, and a source counts as pending only while its line is high.

Top module: `vic_top`

## Requirements
- R1: Each of the 64 request lines (0 to 63) is level-sensitive. `irq_o` is high in any cycle in which at least one line is high, enabled and has priority strictly above the threshold, and low otherwise, with no latching of past requests.
- R2: Writing a value below 64 to address 0 sets the enable bit of that source number and leaves all other enable bits unchanged.
- R3: Writing a value below 64 to address 1 clears the enable bit of that source number and leaves all other enable bits unchanged.
- R4: Writing a value of 64 or more to address 0 or address 1 leaves every enable bit unchanged.
- R5: Writing to address 2 sets the enable of source k for each 1 in bit k (sources 0 to 31). Writing to address 3 does the same for source 32+k. Reads of addresses 2 and 3 return the current enable bits of sources 0 to 31 and 32 to 63, bit k for source k or 32+k.
- R6: Writing to address 4 clears the enable of source k for each 1 in bit k. Address 5 does the same for sources 32 to 63. Zero bits have no effect.
- R7: The priority of source n is held in bits [4*(n%8)+3 : 4*(n%8)] of the word at address 23-(n>>3), so sources 56 to 63 sit at address 16. These words read back as written.
- R8: Address 6 holds the 4-bit threshold in bits [3:0], readable back with the upper bits zero. A source whose priority is at or below the threshold is never selected.
- R9: A read of address 7 returns the winner's source number in bits [31:16] and its priority, zero-extended, in bits [15:0].
- R10: When no source qualifies, a read of address 7 returns 32'hFFFF_FFFF.
- R11: The winner has the highest priority among the qualifying sources. When several qualifying sources share that priority, the highest source number wins.
- R12: After reset all enables, all priorities and the threshold are zero, so address 7 reads all ones and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 64 | Level-sensitive request lines, bit n is source n |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register word address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data, combinational from `addr_i` |
| irq_o | output | 1 | Interrupt request, high while any source qualifies |

## Verification
The bench sweeps every source through enable, disable and selection one at a time. A wrong nibble position or a group address that runs the wrong way shows up as a wrong priority in the status word, or as a missing winner. It fills all sources at one priority to catch a tie-break that favours the lower number, and it sweeps the threshold over all 16 levels to catch an off-by-one that admits sources equal to the threshold. Out-of-range numbers written to the by-number addresses would alias onto a low source if the range check were missing, and the enable readback after those writes reveals it. Random mixes of bulk enables, priorities, request patterns and thresholds are compared against an arithmetic model of the selection rule.

// File: rtl/vic_pkg.sv
package vic_pkg;

   // Register word addresses with fixed meaning
   localparam int unsigned REG_EN_NUM   = 0;
   localparam int unsigned REG_DIS_NUM  = 1;
   localparam int unsigned REG_EN_LO    = 2;
   localparam int unsigned REG_EN_HI    = 3;
   localparam int unsigned REG_DIS_LO   = 4;
   localparam int unsigned REG_DIS_HI   = 5;
   localparam int unsigned REG_MASK     = 6;
   localparam int unsigned REG_VEC      = 7;
   // Lowest address of the priority block (holds the highest source group)
   localparam int unsigned REG_PRIO_LOW = 16;

endpackage

// File: rtl/vic_regs.sv
module vic_regs
   import vic_pkg::*;
#(
   parameter int unsigned NUM_SRC = 64,
   parameter int unsigned PRIO_W  = 4,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 5
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        we_i,
   input  logic [ADDR_W-1:0]           addr_i,
   input  logic [DATA_W-1:0]           wdata_i,
   output logic [NUM_SRC-1:0]          en_o,
   output logic [NUM_SRC*PRIO_W-1:0]   prio_o,
   output logic [PRIO_W-1:0]           mask_o
);

   localparam int unsigned PER_WORD = DATA_W / PRIO_W;
   localparam int unsigned GROUPS   = NUM_SRC / PER_WORD;
   localparam int unsigned SRC_W    = $clog2(NUM_SRC);
   localparam int unsigned PRIO_TOP = REG_PRIO_LOW + GROUPS - 1;

   logic [NUM_SRC-1:0]        en_q, en_d;
   logic [NUM_SRC*PRIO_W-1:0] prio_q;
   logic [PRIO_W-1:0]         mask_q;
   logic [GROUPS-1:0]         prio_hit;
   logic                      num_ok;
   logic [SRC_W-1:0]          num;

   assign num_ok = (wdata_i < DATA_W'(NUM_SRC));
   assign num    = wdata_i[SRC_W-1:0];

   // Enable update: one register write per cycle
   always_comb begin
      en_d = en_q;
      if (we_i) begin
         case (addr_i)
            ADDR_W'(REG_EN_NUM):  if (num_ok) en_d[num] = 1'b1;
            ADDR_W'(REG_DIS_NUM): if (num_ok) en_d[num] = 1'b0;
            ADDR_W'(REG_EN_LO):   en_d[DATA_W-1:0] = en_q[DATA_W-1:0] | wdata_i;
            ADDR_W'(REG_EN_HI):   en_d[NUM_SRC-1:DATA_W] = en_q[NUM_SRC-1:DATA_W] | wdata_i;
            ADDR_W'(REG_DIS_LO):  en_d[DATA_W-1:0] = en_q[DATA_W-1:0] & ~wdata_i;
            ADDR_W'(REG_DIS_HI):  en_d[NUM_SRC-1:DATA_W] = en_q[NUM_SRC-1:DATA_W] & ~wdata_i;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= '0;
      else        en_q <= en_d;
   end

   // Priority word decode: group g lives at PRIO_TOP - g
   for (genvar g = 0; g < GROUPS; g++) begin : g_prio_dec
      assign prio_hit[g] = we_i && (addr_i == ADDR_W'(PRIO_TOP - g));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prio_q <= '0;
      end else begin
         for (int g = 0; g < GROUPS; g++) begin
            if (prio_hit[g]) prio_q[g*DATA_W +: DATA_W] <= wdata_i;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                       mask_q <= '0;
      else if (we_i && addr_i == ADDR_W'(REG_MASK))     mask_q <= wdata_i[PRIO_W-1:0];
   end

   assign en_o   = en_q;
   assign prio_o = prio_q;
   assign mask_o = mask_q;

   // R2
   en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && addr_i == ADDR_W'(REG_EN_NUM) && num_ok) |=> en_q[$past(num)]);

   // R3
   en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && addr_i == ADDR_W'(REG_DIS_NUM) && num_ok) |=> !en_q[$past(num)]);

   // R4
   num_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && !num_ok && (addr_i == ADDR_W'(REG_EN_NUM) || addr_i == ADDR_W'(REG_DIS_NUM)))
      |=> $stable(en_q));

   // R8
   mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(we_i && addr_i == ADDR_W'(REG_MASK)) |=> $stable(mask_q));

endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter #(
   parameter int unsigned NUM_SRC  = 64,
   parameter int unsigned PRIO_W   = 4,
   parameter int unsigned GROUP_SZ = 8,
   parameter bit          SPLIT    = 1'b1
) (
   input  logic [NUM_SRC-1:0]        req_i,
   input  logic [NUM_SRC-1:0]        en_i,
   input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
   input  logic [PRIO_W-1:0]         mask_i,
   output logic                      valid_o,
   output logic [$clog2(NUM_SRC)-1:0] idx_o,
   output logic [PRIO_W-1:0]         prio_o
);

   localparam int unsigned SRC_W  = $clog2(NUM_SRC);
   localparam int unsigned GW     = $clog2(GROUP_SZ);
   localparam int unsigned NGROUP = NUM_SRC / GROUP_SZ;

   logic [NUM_SRC-1:0] elig;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_elig
      assign elig[i] = req_i[i] && en_i[i] && (prio_i[i*PRIO_W +: PRIO_W] > mask_i);
   end

   if (!SPLIT) begin : g_flat
      // Single scan across all sources; >= lets the higher number win ties
      always_comb begin
         valid_o = 1'b0;
         idx_o   = '0;
         prio_o  = '0;
         for (int i = 0; i < NUM_SRC; i++) begin
            if (elig[i] && (!valid_o || prio_i[i*PRIO_W +: PRIO_W] >= prio_o)) begin
               valid_o = 1'b1;
               idx_o   = SRC_W'(i);
               prio_o  = prio_i[i*PRIO_W +: PRIO_W];
            end
         end
      end
   end else begin : g_split
      logic [NGROUP-1:0]        gv;
      logic [NGROUP*GW-1:0]     gi;
      logic [NGROUP*PRIO_W-1:0] gp;

      for (genvar g = 0; g < NGROUP; g++) begin : g_grp
         logic              lv;
         logic [GW-1:0]     li;
         logic [PRIO_W-1:0] lp;
         always_comb begin
            lv = 1'b0;
            li = '0;
            lp = '0;
            for (int k = 0; k < GROUP_SZ; k++) begin
               if (elig[g*GROUP_SZ+k] &&
                   (!lv || prio_i[(g*GROUP_SZ+k)*PRIO_W +: PRIO_W] >= lp)) begin
                  lv = 1'b1;
                  li = GW'(k);
                  lp = prio_i[(g*GROUP_SZ+k)*PRIO_W +: PRIO_W];
               end
            end
         end
         assign gv[g]                 = lv;
         assign gi[g*GW +: GW]        = li;
         assign gp[g*PRIO_W +: PRIO_W] = lp;
      end

      always_comb begin
         valid_o = 1'b0;
         idx_o   = '0;
         prio_o  = '0;
         for (int g = 0; g < NGROUP; g++) begin
            if (gv[g] && (!valid_o || gp[g*PRIO_W +: PRIO_W] >= prio_o)) begin
               valid_o = 1'b1;
               idx_o   = SRC_W'(g*GROUP_SZ) + SRC_W'(gi[g*GW +: GW]);
               prio_o  = gp[g*PRIO_W +: PRIO_W];
            end
         end
      end
   end

endmodule

// File: rtl/vic_top.sv
module vic_top
   import vic_pkg::*;
#(
   parameter int unsigned NUM_SRC  = 64,
   parameter int unsigned PRIO_W   = 4,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned ADDR_W   = 5,
   parameter int unsigned GROUP_SZ = 8,
   parameter bit          SPLIT    = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [63:0]        src_i,
   input  logic               we_i,
   input  logic [4:0]         addr_i,
   input  logic [31:0]        wdata_i,
   output logic [31:0]        rdata_o,
   output logic               irq_o
);

   localparam int unsigned SRC_W    = $clog2(NUM_SRC);
   localparam int unsigned PER_WORD = DATA_W / PRIO_W;
   localparam int unsigned GROUPS   = NUM_SRC / PER_WORD;
   localparam int unsigned HALF_W   = DATA_W / 2;
   localparam int unsigned PRIO_TOP = REG_PRIO_LOW + GROUPS - 1;

   // Elaboration-time parameter checks
   initial begin
      if (NUM_SRC != 64 || DATA_W != 32 || ADDR_W != 5)
         $error("vic_top: port widths fixed at 64 sources, 32-bit data, 5-bit address");
      if (NUM_SRC != 2 * DATA_W)
         $error("vic_top: bulk registers need NUM_SRC == 2*DATA_W");
      if (DATA_W % PRIO_W != 0 || NUM_SRC % PER_WORD != 0)
         $error("vic_top: priorities must pack evenly into words");
      if (NUM_SRC % GROUP_SZ != 0 || (1 << $clog2(GROUP_SZ)) != GROUP_SZ)
         $error("vic_top: GROUP_SZ must be a power of two dividing NUM_SRC");
      if (SRC_W > HALF_W || PRIO_W > HALF_W)
         $error("vic_top: vector fields overflow");
      if (PRIO_TOP >= (1 << ADDR_W))
         $error("vic_top: priority block exceeds address space");
   end

   logic [NUM_SRC-1:0]        en;
   logic [NUM_SRC*PRIO_W-1:0] prio;
   logic [PRIO_W-1:0]         mask;
   logic                      win_v;
   logic [SRC_W-1:0]          win_idx;
   logic [PRIO_W-1:0]         win_prio;
   logic [DATA_W-1:0]         vec;

   vic_regs #(
      .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
      .en_o(en), .prio_o(prio), .mask_o(mask)
   );

   vic_arbiter #(
      .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .GROUP_SZ(GROUP_SZ), .SPLIT(SPLIT)
   ) u_arb (
      .req_i(src_i), .en_i(en), .prio_i(prio), .mask_i(mask),
      .valid_o(win_v), .idx_o(win_idx), .prio_o(win_prio)
   );

   assign irq_o = win_v;
   assign vec   = win_v ? {HALF_W'(win_idx), HALF_W'(win_prio)} : '1;

   always_comb begin
      rdata_o = '0;
      if (addr_i >= ADDR_W'(REG_PRIO_LOW) && addr_i <= ADDR_W'(PRIO_TOP)) begin
         for (int g = 0; g < GROUPS; g++) begin
            if (addr_i == ADDR_W'(PRIO_TOP - g)) rdata_o = prio[g*DATA_W +: DATA_W];
         end
      end else begin
         case (addr_i)
            ADDR_W'(REG_EN_LO): rdata_o = en[DATA_W-1:0];
            ADDR_W'(REG_EN_HI): rdata_o = en[NUM_SRC-1:DATA_W];
            ADDR_W'(REG_MASK):  rdata_o = DATA_W'(mask);
            ADDR_W'(REG_VEC):   rdata_o = vec;
            default:            rdata_o = '0;
         endcase
      end
   end

   // R1
   irq_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (src_i[win_idx] && en[win_idx]));

   // R1
   irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src_i == '0) |-> !irq_o);

   // R8
   above_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (win_prio > mask));

   // R10
   vec_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_o && addr_i == ADDR_W'(REG_VEC)) |-> (rdata_o == '1));

endmodule

// File: tb/vic_top_tb.sv
`timescale 1ns/1ps
module vic_top_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] src = '0;
   logic        we = 1'b0;
   logic [4:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   // Model state
   bit          m_en [64];
   logic [3:0]  m_pr [64];
   logic [3:0]  m_mask;

   always #4 clk = ~clk;

   vic_top dut_i (
      .clk(clk), .rst_n(rst_n), .src_i(src), .we_i(we), .addr_i(addr),
      .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      we = 1'b1; addr = 5'(a); wdata = d;
      @(negedge clk);
      we = 1'b0;
      case (a)
         0: if (d < 64) m_en[d[5:0]] = 1'b1;
         1: if (d < 64) m_en[d[5:0]] = 1'b0;
         2: for (int k = 0; k < 32; k++) if (d[k]) m_en[k] = 1'b1;
         3: for (int k = 0; k < 32; k++) if (d[k]) m_en[32+k] = 1'b1;
         4: for (int k = 0; k < 32; k++) if (d[k]) m_en[k] = 1'b0;
         5: for (int k = 0; k < 32; k++) if (d[k]) m_en[32+k] = 1'b0;
         6: m_mask = d[3:0];
         default:
            if (a >= 16 && a <= 23)
               for (int k = 0; k < 8; k++) m_pr[(23-a)*8+k] = d[4*k +: 4];
      endcase
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      addr = 5'(a);
      #1;
      d = rdata;
   endtask

   function automatic logic [31:0] exp_vec();
      int best = -1;
      for (int i = 0; i < 64; i++)
         if (src[i] && m_en[i] && m_pr[i] > m_mask && (best < 0 || m_pr[i] >= m_pr[best]))
            best = i;
      if (best < 0) return 32'hFFFF_FFFF;
      return {16'(best), 12'd0, m_pr[best]};
   endfunction

   task automatic chk_vec(input string req);
      logic [31:0] v, e;
      e = exp_vec();
      rd(7, v);
      chk(req, v, e);
      chk({req, " irq"}, {31'd0, irq}, {31'd0, e != 32'hFFFF_FFFF});
   endtask

   task automatic chk_en(input string req);
      logic [31:0] v, e;
      for (int h = 0; h < 2; h++) begin
         for (int k = 0; k < 32; k++) e[k] = m_en[h*32+k];
         rd(2 + h, v);
         chk(req, v, e);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual running expected finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      for (int i = 0; i < 64; i++) begin m_en[i] = 1'b0; m_pr[i] = '0; end
      m_mask = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R12 reset state
      src = '1;
      chk_vec("R12 vector after reset");
      chk_en("R12 enables after reset");
      for (int a = 16; a < 24; a++) begin rd(a, v); chk("R12 priority after reset", v, 0); end
      rd(6, v); chk("R12 threshold after reset", v, 0);
      src = '0;

      // R7 priority packing and readback
      for (int a = 16; a < 24; a++) begin
         wr(a, 32'h1234_5678 ^ (32'(a) * 32'h0101_0101) | 32'h1111_1111);
      end
      for (int a = 16; a < 24; a++) begin
         logic [31:0] e;
         for (int k = 0; k < 8; k++) e[4*k +: 4] = m_pr[(23-a)*8+k];
         rd(a, v); chk("R7 priority readback", v, e);
      end
      for (int g = 0; g < 8; g++) begin
         logic [31:0] w;
         for (int k = 0; k < 8; k++) w[4*k +: 4] = 4'(((g*8+k)*5) % 15 + 1);
         wr(23 - g, w);
      end

      // R2 R3 R7 R9 one source at a time
      for (int n = 0; n < 64; n++) begin
         src = 64'd1 << n;
         wr(0, n);
         chk_vec("R2 R7 R9 single source selected");
         chk_en("R2 single enable set");
         wr(1, n);
         chk_vec("R3 R10 single source disabled");
      end

      // R1 level behaviour
      wr(0, 10);
      src = 64'd1 << 10; chk_vec("R1 line high");
      src = '0;          chk_vec("R1 line low drops irq");
      src = 64'd1 << 10; chk_vec("R1 line high again");
      wr(1, 10);

      // R4 out-of-range numbers
      wr(2, 32'hFFFF_FFFF); wr(3, 32'hFFFF_FFFF);
      wr(1, 64); wr(1, 65); wr(1, 127); wr(1, 32'hFFFF_0000); wr(1, 32'h0000_0100);
      chk_en("R4 disable by number out of range");
      wr(4, 32'hFFFF_FFFF); wr(5, 32'hFFFF_FFFF);
      chk_en("R6 bulk disable all");
      wr(0, 64); wr(0, 200); wr(0, 32'h8000_0000); wr(0, 32'h0000_0040);
      chk_en("R4 enable by number out of range");

      // R8 R11 threshold sweep with all sources active
      wr(2, 32'hFFFF_FFFF); wr(3, 32'hFFFF_FFFF);
      src = '1;
      for (int m = 0; m < 16; m++) begin
         wr(6, 32'hFFFF_FFF0 | 32'(m));
         rd(6, v); chk("R8 threshold readback", v, m);
         chk_vec("R8 R11 threshold sweep");
      end

      // R11 equal priority ties
      wr(6, 0);
      for (int a = 16; a < 24; a++) wr(a, 32'h5555_5555);
      for (int t = 0; t < 40; t++) begin
         src = {$urandom, $urandom};
         chk_vec("R11 tie goes to higher number");
      end

      // Random mixes
      for (int it = 0; it < 300; it++) begin
         case ($urandom % 6)
            0: wr(2, $urandom);
            1: wr(3, $urandom);
            2: wr(4, $urandom);
            3: wr(5, $urandom);
            4: wr(16 + ($urandom % 8), $urandom);
            default: wr(6, $urandom % 6);
         endcase
         src = {$urandom, $urandom};
         chk_vec("R5 R6 R9 R11 random mix");
         if (it % 25 == 0) chk_en("R5 R6 enable readback");
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule